// File: doc/BRIEF.md
# I/O Bus Cycle Sequencer

This block sits on the processor side of a multiplexed address/data bus. It turns one internal I/O request into one or two complete bus cycles. A request names a direction, a port, a byte or word size and, for writes, the data. The port is given either as a short 8-bit number or as a full 16-bit address. The sequencer steps through four bus states per cycle. It drives the address strobe, the I/O status line, the byte-high-enable, the read and write strobes, the data-enable and the data direction. It captures read data during the third state.

The bus width is chosen per request. On a 16-bit bus the sequencer uses the byte lanes that the port address selects. A word at an odd port is split into two byte cycles. On an 8-bit bus every word becomes two byte cycles on the low data lines. While a request is in progress a busy flag holds off new requests. A one-clock done pulse ends the request, and the 16-bit read result is available at that point.

Top module: `io_bus_seq`

## Requirements
- R1: After reset the sequencer is idle: busy=0, done=0, ale=0, io_status=0, rd_n=1, wr_n=1, den_n=1.
- R2: Each bus cycle lasts four clocks (T1..T4). In T1 only, ale=1 and ad_out carries the 16-bit port address. a_hi (address bits 19..16) is 0, and io_status is 1 from T1 through T4.
- R3: In a read cycle, rd_n and den_n are low in T2 and T3 and dt_r=0. The sequencer does not drive the bus (ad_oe=0) and samples ad_in at the end of T3.
- R4: In a write cycle, dt_r=1. Data is driven (ad_oe=1) in T2, T3 and T4, and wr_n is low in T2 and T3.
- R5: On the 16-bit bus, byte lanes are selected from the address and the size. A byte at an even port uses ad[7:0] with bhe_n=1. A byte at an odd port uses ad[15:8] with bhe_n=0. A word at an even port takes one cycle on ad[15:0] with bhe_n=0.
- R6: On the 16-bit bus, a word at an odd port P takes two cycles. The first cycle is at P, on ad[15:8] with bhe_n=0, and carries the low byte. The second cycle is at P+1 (modulo 2^16), on ad[7:0] with bhe_n=1, and carries the high byte.
- R7: On the 8-bit bus (bus8_mode=1 at request time), bhe_n stays 1. A byte takes one cycle on ad[7:0]. A word takes two cycles, at P (low byte) and then at P+1 (high byte). While write data is driven, ad[15:8] carries the cycle's address bits 15..8.
- R8: When req_direct=1, the port address is {8'h00, req_port[7:0]}, and the upper bits of req_port are ignored.
- R9: done is high for exactly one clock, in the clock after the final T4. rd_data then holds the read result. A word read returns the high byte in bits 15..8 and the low byte in bits 7..0. A byte read is zero-extended. A write returns 0.
- R10: busy is high from the first T1 to the final T4. A req_valid seen while busy is ignored and starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_direct | input | 1 | 1 = 8-bit port number form |
| req_port | input | 16 | Port address or number |
| req_wdata | input | 16 | Write data |
| bus8_mode | input | 1 | 1 = 8-bit data bus for this request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Assembled read result |
| ad_out | output | 16 | Address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Address/data lines, incoming value |
| a_hi | output | 4 | Address bits 19..16 |
| ale | output | 1 | Address latch strobe |
| io_status | output | 1 | High during I/O bus cycles |
| bhe_n | output | 1 | Byte-high-enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable, active low |
| dt_r | output | 1 | Data direction, 1 = transmit |

## Verification
A corrupt state register or phase bit shows up within one cycle. It appears as a missing or extra ale pulse, a strobe count other than two per cycle, or a bus cycle that the scoreboard did not expect. A wrong split decision changes the number of bus cycles before done. A wrong lane choice changes bhe_n at the next T1, or the masked data byte during T2. A capture error reaches the ports only as a wrong rd_data at the done pulse. The bench compares that value for every read request.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } bus_state_e;

    typedef enum logic [1:0] {
        LANE_LO,
        LANE_HI,
        LANE_BOTH
    } lane_e;

endpackage

// File: rtl/io_seq_plan.sv
// Works out, for the current phase of a request, the cycle address, the lane
// use, the byte-high-enable and the write value placed on the bus.
module io_seq_plan
    import io_seq_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 16,
    localparam int LANE_W = DATA_W / 2
) (
    input  logic [PORT_W-1:0] base_addr,
    input  logic              is_word,
    input  logic              bus8,
    input  logic              phase,
    input  logic [DATA_W-1:0] wdata,
    output logic              split,
    output logic [PORT_W-1:0] cyc_addr,
    output lane_e             lane,
    output logic              cyc_bhe_n,
    output logic [DATA_W-1:0] bus_wdata
);

    logic [LANE_W-1:0] byte_sel;

    always_comb begin
        split     = is_word && (bus8 || base_addr[0]);
        cyc_addr  = base_addr + {{(PORT_W-1){1'b0}}, phase};
        byte_sel  = phase ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
        lane      = LANE_LO;
        cyc_bhe_n = 1'b1;
        bus_wdata = '0;
        if (bus8) begin
            // narrow bus: upper lines keep the address byte
            lane      = LANE_LO;
            cyc_bhe_n = 1'b1;
            bus_wdata = {cyc_addr[PORT_W-1 -: LANE_W], byte_sel};
        end else if (is_word && !split) begin
            lane      = LANE_BOTH;
            cyc_bhe_n = 1'b0;
            bus_wdata = wdata;
        end else if (cyc_addr[0]) begin
            lane      = LANE_HI;
            cyc_bhe_n = 1'b0;
            bus_wdata = {byte_sel, {LANE_W{1'b0}}};
        end else begin
            lane      = LANE_LO;
            cyc_bhe_n = 1'b1;
            bus_wdata = {{LANE_W{1'b0}}, byte_sel};
        end
    end

endmodule

// File: rtl/io_seq_pins.sv
// Decodes the bus pins from the sequencer state.
module io_seq_pins
    import io_seq_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 16,
    parameter int HI_W   = 4
) (
    input  bus_state_e        st,
    input  logic              write,
    input  logic [PORT_W-1:0] cyc_addr,
    input  logic              cyc_bhe_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              ale,
    output logic              io_status,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r
);

    logic active;
    logic strobe_win;
    logic data_win;

    always_comb begin
        active     = (st != ST_IDLE);
        strobe_win = (st == ST_T2) || (st == ST_T3);
        data_win   = strobe_win || (st == ST_T4);

        ale        = (st == ST_T1);
        io_status  = active;
        a_hi       = '0;
        bhe_n      = active ? cyc_bhe_n : 1'b1;
        dt_r       = active && write;
        rd_n       = !(strobe_win && !write);
        wr_n       = !(strobe_win && write);
        den_n      = !(strobe_win || (data_win && write));
        ad_oe      = ale || (data_win && write);
        if (ale)
            ad_out = DATA_W'(cyc_addr);
        else if (data_win && write)
            ad_out = bus_wdata;
        else
            ad_out = '0;
    end

endmodule

// File: rtl/io_bus_seq.sv
module io_bus_seq
    import io_seq_pkg::*;
#(
    parameter int PORT_W   = 16,
    parameter int DATA_W   = 16,
    parameter int HI_W     = 4,
    parameter int DIRECT_W = 8,
    localparam int LANE_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_direct,
    input  logic [PORT_W-1:0] req_port,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus8_mode,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi,
    output logic              ale,
    output logic              io_status,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r
);

    typedef struct packed {
        bus_state_e        st;
        logic              phase;
        logic              write;
        logic              word;
        logic              bus8;
        logic [PORT_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              split;
    logic [PORT_W-1:0] cyc_addr;
    lane_e             lane;
    logic              cyc_bhe_n;
    logic [DATA_W-1:0] bus_wdata;
    logic [LANE_W-1:0] in_byte;

    io_seq_plan #(.PORT_W(PORT_W), .DATA_W(DATA_W)) plan_i (
        .base_addr (q.addr),
        .is_word   (q.word),
        .bus8      (q.bus8),
        .phase     (q.phase),
        .wdata     (q.wdata),
        .split     (split),
        .cyc_addr  (cyc_addr),
        .lane      (lane),
        .cyc_bhe_n (cyc_bhe_n),
        .bus_wdata (bus_wdata)
    );

    io_seq_pins #(.PORT_W(PORT_W), .DATA_W(DATA_W), .HI_W(HI_W)) pins_i (
        .st        (q.st),
        .write     (q.write),
        .cyc_addr  (cyc_addr),
        .cyc_bhe_n (cyc_bhe_n),
        .bus_wdata (bus_wdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .ale       (ale),
        .io_status (io_status),
        .bhe_n     (bhe_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .den_n     (den_n),
        .dt_r      (dt_r)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        in_byte = (lane == LANE_HI) ? ad_in[DATA_W-1:LANE_W] : ad_in[LANE_W-1:0];
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_T1;
                    d.phase = 1'b0;
                    d.write = req_write;
                    d.word  = req_word;
                    d.bus8  = bus8_mode;
                    d.addr  = req_direct ? {{(PORT_W-DIRECT_W){1'b0}}, req_port[DIRECT_W-1:0]}
                                         : req_port;
                    d.wdata = req_wdata;
                    d.rdata = '0;
                end
            end
            ST_T1: d.st = ST_T2;
            ST_T2: d.st = ST_T3;
            ST_T3: begin
                d.st = ST_T4;
                if (!q.write) begin
                    if (lane == LANE_BOTH)
                        d.rdata = ad_in;
                    else if (q.phase)
                        d.rdata[DATA_W-1:LANE_W] = in_byte;
                    else
                        d.rdata[LANE_W-1:0] = in_byte;
                end
            end
            ST_T4: begin
                if (split && !q.phase) begin
                    d.phase = 1'b1;
                    d.st    = ST_T1;
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign rd_data = q.rdata;

endmodule

// File: rtl/io_bus_seq_chk.sv
module io_bus_seq_chk #(
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            ale,
    input logic [HI_W-1:0] a_hi,
    input logic            io_status,
    input logic            rd_n,
    input logic            wr_n,
    input logic            den_n,
    input logic            dt_r,
    input logic            ad_oe
);

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r2_t1_status: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (a_hi == '0) && io_status);

    a_r3_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe && !dt_r && !den_n && wr_n);

    a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe && dt_r && !den_n && rd_n);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || !rd_n || !wr_n || io_status) |-> busy);

endmodule

bind io_bus_seq io_bus_seq_chk #(.HI_W(HI_W)) chk_i (.*);

// File: tb/io_bus_seq_tb.sv
module io_bus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_direct = 1'b0;
    logic [15:0] req_port = '0, req_wdata = '0;
    logic        bus8_mode = 1'b0;
    logic        busy, done, ad_oe, ale, io_status, bhe_n, rd_n, wr_n, den_n, dt_r;
    logic [15:0] rd_data, ad_out, ad_in;
    logic [3:0]  a_hi;

    int vectors = 0;
    int miscompares = 0;
    int dones = 0;

    always #10 clk = ~clk;

    io_bus_seq dut_i (.*);

    typedef struct packed {
        logic [15:0] addr;
        logic        bhe_n;
        logic        wr;
        logic [15:0] data;
        logic [15:0] mask;
    } cyc_t;

    cyc_t        bus_q[$];
    logic [15:0] rd_q[$];

    function automatic logic [7:0] dv(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // device model: answers from the latched address
    logic [15:0] la = '0;
    logic        cur_bus8 = 1'b0;
    assign ad_in = cur_bus8 ? {8'hC3, dv(la)} : {dv(la | 16'h1), dv(la & 16'hFFFE)};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic b, input logic w,
                        input logic [15:0] dd, input logic [15:0] m);
        cyc_t c;
        c.addr = a; c.bhe_n = b; c.wr = w; c.data = dd; c.mask = m;
        bus_q.push_back(c);
    endtask

    // driver: builds the expected bus cycles, then issues the request
    task automatic issue(input logic wr, input logic word, input logic direct,
                         input logic [15:0] port, input logic [15:0] w,
                         input logic b8, input bit spam);
        logic [15:0] ea, ea1;
        int target;
        ea  = direct ? {8'h00, port[7:0]} : port;
        ea1 = ea + 16'd1;
        if (b8) begin
            push(ea, 1'b1, wr, {ea[15:8], w[7:0]}, 16'hFFFF);
            if (word) push(ea1, 1'b1, wr, {ea1[15:8], w[15:8]}, 16'hFFFF);
        end else if (word && !ea[0]) begin
            push(ea, 1'b0, wr, w, 16'hFFFF);
        end else if (word) begin
            push(ea, 1'b0, wr, {w[7:0], 8'h00}, 16'hFF00);
            push(ea1, 1'b1, wr, {8'h00, w[15:8]}, 16'h00FF);
        end else if (ea[0]) begin
            push(ea, 1'b0, wr, {w[7:0], 8'h00}, 16'hFF00);
        end else begin
            push(ea, 1'b1, wr, {8'h00, w[7:0]}, 16'h00FF);
        end
        rd_q.push_back(wr ? 16'h0000 : (word ? {dv(ea1), dv(ea)} : {8'h00, dv(ea)}));

        @(negedge clk);
        while (busy) @(negedge clk);
        target     = dones + 1;
        req_write  = wr; req_word = word; req_direct = direct;
        req_port   = port; req_wdata = w; bus8_mode = b8; cur_bus8 = b8;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        if (spam) begin
            chk(busy === 1'b1, "R10 busy during cycle", busy, 1);
            req_valid = 1'b1; req_port = ~port; req_write = ~wr;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (dones < target) @(negedge clk);
    endtask

    // monitor: compares the bus and the results against the queues
    cyc_t cur;
    bit   in_cyc = 0;
    int   strb = 0;
    logic prev_io = 0, prev_ale = 0, prev_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                if (in_cyc) chk(strb == 2, "R3/R4 strobe clocks per cycle", strb, 2);
                strb = 0;
                if (bus_q.size() == 0) begin
                    chk(0, "R10 unexpected bus cycle", ad_out, 0);
                    in_cyc = 0;
                end else begin
                    cur = bus_q.pop_front();
                    in_cyc = 1;
                    la = ad_out;
                    chk({a_hi, ad_out} == {4'h0, cur.addr}, "R2/R8 T1 address", {a_hi, ad_out}, {4'h0, cur.addr});
                    chk(io_status === 1'b1, "R2 io_status in T1", io_status, 1);
                    chk(bhe_n === cur.bhe_n, "R5/R6/R7 bhe_n", bhe_n, cur.bhe_n);
                end
            end else if (in_cyc && io_status) begin
                if (!rd_n || !wr_n) strb++;
                if (cur.wr) begin
                    chk(ad_oe === 1'b1 && dt_r === 1'b1, "R4 write drive T2..T4", {ad_oe, dt_r}, 2'b11);
                    chk((ad_out & cur.mask) == (cur.data & cur.mask), "R4/R5/R6/R7 write data",
                        ad_out & cur.mask, cur.data & cur.mask);
                    chk(rd_n === 1'b1, "R4 no read strobe", rd_n, 1);
                end else begin
                    chk(wr_n === 1'b1 && ad_oe === 1'b0, "R3 read releases bus", {wr_n, ad_oe}, 2'b10);
                    if (!rd_n) chk(den_n === 1'b0 && dt_r === 1'b0, "R3 read enables", {den_n, dt_r}, 2'b00);
                end
            end
            if (done) begin
                if (in_cyc) chk(strb == 2, "R3/R4 strobe clocks per cycle", strb, 2);
                in_cyc = 0;
                chk(prev_io && !prev_ale && !prev_done, "R9 done follows T4", {prev_io, prev_ale, prev_done}, 3'b100);
                chk(bus_q.size() == 0, "R6/R7 bus cycles before done", bus_q.size(), 0);
                if (rd_q.size() != 0) begin
                    logic [15:0] e;
                    e = rd_q.pop_front();
                    chk(rd_data == e, "R9 rd_data", rd_data, e);
                end
                dones++;
            end
            if (prev_done) chk(done === 1'b0, "R9 done one clock", done, 0);
            prev_io = io_status; prev_ale = ale; prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && ale === 0 && io_status === 0, "R1 reset idle",
            {busy, done, ale, io_status}, 0);
        chk(rd_n === 1 && wr_n === 1 && den_n === 1, "R1 reset strobes", {rd_n, wr_n, den_n}, 3'b111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 0 && io_status === 0, "R1 idle after release", {busy, io_status}, 0);

        // 16-bit bus
        issue(1, 0, 0, 16'h0040, 16'h77AB, 0, 0);  // R5 even byte write
        issue(1, 0, 0, 16'h0041, 16'h77CD, 0, 0);  // R5 odd byte write
        issue(1, 1, 0, 16'h1234, 16'hBEEF, 0, 0);  // R5 aligned word write
        issue(1, 1, 0, 16'h2345, 16'hA1B2, 0, 0);  // R6 misaligned word write
        issue(0, 0, 0, 16'h3310, 16'h0000, 0, 0);  // R3 even byte read
        issue(0, 0, 0, 16'h3311, 16'h0000, 0, 1);  // R3/R10 odd byte read, busy spam
        issue(0, 1, 0, 16'h8000, 16'h0000, 0, 0);  // R5 aligned word read
        issue(0, 1, 0, 16'h8003, 16'h0000, 0, 0);  // R6 misaligned word read
        issue(0, 1, 0, 16'hFFFF, 16'h0000, 0, 0);  // R6 wrap to 0000
        issue(0, 0, 1, 16'h12FE, 16'h0000, 0, 0);  // R8 direct read
        issue(1, 1, 1, 16'hABCD, 16'h5566, 0, 1);  // R8/R6/R10 direct odd word write
        // 8-bit bus
        issue(1, 0, 0, 16'h4C20, 16'h0099, 1, 0);  // R7 byte write
        issue(1, 1, 0, 16'h4CFF, 16'h1357, 1, 0);  // R7 word write across page
        issue(0, 0, 0, 16'h0A07, 16'h0000, 1, 0);  // R7 byte read
        issue(0, 1, 0, 16'h0A06, 16'h0000, 1, 0);  // R7 even word read still split
        issue(0, 1, 1, 16'h77F1, 16'h0000, 1, 0);  // R7/R8 direct word read
        repeat (4) @(negedge clk);
        chk(bus_q.size() == 0 && busy === 0, "R10 no stray cycles", bus_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule